// File: doc/BRIEF.md
# Isolated Upstream Port Attach Supervisor

This block decides when a peripheral sitting behind an isolation barrier appears connected to a USB host. It drives the upstream pull-up, picking D+ for full speed or D- for low speed. It also drives the enable for the downstream pull-downs and two force-off commands for the data drivers on each side of the barrier. A mismatch between the two speed straps raises a sticky error flag. The host-side and peripheral-side power-good inputs, the peripheral's attach request and a bit-rate tick set every output. Data forwarding is handled elsewhere.

The attach sequencer has four named states. LINK_DETACHED has no pull-up and the upstream drivers forced off. LINK_ATTACHED has the pull-up applied. LINK_HOLD means peripheral-side power has vanished and the pull-up is kept while a bit-time timeout runs. LINK_FAULT is the sticky speed-mismatch state. The transitions are:

- attach: DETACHED to ATTACHED when the request and both power-goods are high.
- withdraw: ATTACHED to DETACHED when the request falls.
- host_loss: ATTACHED or HOLD to DETACHED when host-side power fails.
- far_loss: ATTACHED to HOLD when peripheral-side power fails.
- recover: HOLD back to ATTACHED, or to DETACHED if the request is low, when peripheral-side power returns.
- expire: HOLD to DETACHED when the timeout ends.
- mismatch: any state to FAULT.

Each side has a loss timer with states LT_RELEASED, LT_ARMED and LT_DRAIN. Transitions:

- arm: any state to ARMED while the watched power-good is high, which also clears the count.
- start: ARMED to DRAIN when the power-good is first seen low.
- tick: DRAIN counts one bit-rate tick.
- expire: DRAIN to RELEASED on the LOSS_TICKS-th tick.

Top module: `iso_attach_sup`

## Requirements
- R1: While reset is asserted, and right after it, both pull-up outputs, `pd_en` and `spd_err` are 0, and `up_drv_off` and `dn_drv_off` are 1.
- R2: `pd_en` equals the value of `pd_strap` sampled at the first clock edge after reset is released. Later changes of `pd_strap` have no effect until the next reset.
- R3: With both power-goods high and matching speed straps, the edge that samples `pu_req` high turns the pull-up on and clears `up_drv_off`. The edge that samples `pu_req` low, with peripheral power present, turns the pull-up off and sets `up_drv_off`.
- R4: The pull-up is driven on `pu_dp_en` when `up_fs_sel` is 1 (full speed) and on `pu_dm_en` when it is 0 (low speed). The two are never high together.
- R5: The edge that samples `up_pwr_ok` low removes the pull-up and sets `up_drv_off`.
- R6: If `dn_pwr_ok` is sampled low while attached, the pull-up stays on and `up_drv_off` stays low, whatever `pu_req` does, until the edge that samples the LOSS_TICKS-th `bit_tick` after that edge. At that edge both are released.
- R7: Peripheral power returning during the hold cancels the release and clears the tick count. A later loss counts from zero.
- R8: After the edge that samples `up_pwr_ok` low, `dn_drv_off` rises at the edge that samples the LOSS_TICKS-th `bit_tick`. It clears at the first edge that samples `up_pwr_ok` high.
- R9: After reset, `dn_drv_off` stays high until the first edge that samples `up_pwr_ok` high.
- R10: Any edge that samples `up_fs_sel` different from `dn_fs_sel` sets `spd_err`. From then on the pull-up is off and `up_drv_off` is 1 until reset, even if the straps match again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_pwr_ok | input | 1 | Host-side power good |
| dn_pwr_ok | input | 1 | Peripheral-side power good |
| pu_req | input | 1 | Peripheral request to attach (pull-up enable) |
| pd_strap | input | 1 | Pull-down enable strap, sampled after reset |
| up_fs_sel | input | 1 | Host-side speed strap, 1 = full speed |
| dn_fs_sel | input | 1 | Peripheral-side speed strap, 1 = full speed |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| pu_dp_en | output | 1 | Upstream pull-up on D+ |
| pu_dm_en | output | 1 | Upstream pull-up on D- |
| pd_en | output | 1 | Downstream pull-down enable |
| up_drv_off | output | 1 | Force host-side data drivers to high impedance |
| dn_drv_off | output | 1 | Force peripheral-side data drivers to high impedance |
| spd_err | output | 1 | Sticky speed-strap mismatch flag |

## Verification
The assertions check the following on every cycle:

- The timeout bounds, against tick counters kept in the checker.
- The instant detach on host power loss.
- That the mismatch flag is sticky and keeps the pull-up quiet.
- The speed-to-line mapping.
- That the strap output never moves once sampled.

Only the bench scenarios show the exact release cycle, that is, that the pull-up survives exactly LOSS_TICKS-1 ticks. They also show the count restarting after a brief power return, the strap being ignored after capture, and the detached state at reset. The bench compares all six outputs against a behavioural model on every clock, under random power, request and tick patterns.

// File: rtl/iso_attach_pkg.sv
package iso_attach_pkg;

    typedef enum logic [1:0] {
        LINK_DETACHED = 2'd0,
        LINK_ATTACHED = 2'd1,
        LINK_HOLD     = 2'd2,
        LINK_FAULT    = 2'd3
    } link_state_e;

    typedef enum logic [1:0] {
        LT_RELEASED = 2'd0,
        LT_ARMED    = 2'd1,
        LT_DRAIN    = 2'd2
    } loss_state_e;

endpackage

// File: rtl/iso_loss_timer.sv
module iso_loss_timer
    import iso_attach_pkg::*;
#(
    parameter int LOSS_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic bit_tick,
    output logic expire
);

    localparam int CW = $clog2(LOSS_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(LOSS_TICKS - 1);

    loss_state_e     st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LT_RELEASED;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: power present re-arms and clears the count
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (pwr_ok) begin
            st_d  = LT_ARMED;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                LT_ARMED: begin
                    st_d  = LT_DRAIN;
                    cnt_d = '0;
                end
                LT_DRAIN: begin
                    if (bit_tick) begin
                        if (cnt_q == LAST) begin
                            st_d  = LT_RELEASED;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                LT_RELEASED: begin
                    st_d = LT_RELEASED;
                end
                default: begin
                    st_d  = LT_RELEASED;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        expire = (st_q == LT_DRAIN) && !pwr_ok && bit_tick && (cnt_q == LAST);
    end

endmodule

// File: rtl/iso_strap_latch.sv
module iso_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    output logic pd_en
);

    logic taken_q;
    logic value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            value_q <= 1'b0;
        end else if (!taken_q) begin
            taken_q <= 1'b1;
            value_q <= strap;
        end
    end

    always_comb begin
        pd_en = value_q;
    end

endmodule

// File: rtl/iso_attach_fsm.sv
module iso_attach_fsm
    import iso_attach_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_pwr_ok,
    input  logic dn_pwr_ok,
    input  logic pu_req,
    input  logic up_fs_sel,
    input  logic dn_fs_sel,
    input  logic hold_expire,
    output logic pu_dp_en,
    output logic pu_dm_en,
    output logic link_off,
    output logic spd_err
);

    link_state_e st_q, st_d;
    logic        mismatch;
    logic        pull;

    assign mismatch = up_fs_sel ^ dn_fs_sel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LINK_DETACHED;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (st_q != LINK_FAULT && mismatch) begin
            st_d = LINK_FAULT;                       // mismatch
        end else begin
            unique case (st_q)
                LINK_DETACHED: begin
                    if (pu_req && up_pwr_ok && dn_pwr_ok)
                        st_d = LINK_ATTACHED;        // attach
                end
                LINK_ATTACHED: begin
                    if (!up_pwr_ok)      st_d = LINK_DETACHED;   // host_loss
                    else if (!dn_pwr_ok) st_d = LINK_HOLD;       // far_loss
                    else if (!pu_req)    st_d = LINK_DETACHED;   // withdraw
                end
                LINK_HOLD: begin
                    if (!up_pwr_ok)      st_d = LINK_DETACHED;   // host_loss
                    else if (dn_pwr_ok)  st_d = pu_req ? LINK_ATTACHED
                                                       : LINK_DETACHED; // recover
                    else if (hold_expire) st_d = LINK_DETACHED;  // expire
                end
                LINK_FAULT: begin
                    st_d = LINK_FAULT;
                end
                default: st_d = LINK_DETACHED;
            endcase
        end
    end

    // outputs
    always_comb begin
        pull     = (st_q == LINK_ATTACHED) || (st_q == LINK_HOLD);
        pu_dp_en = pull && up_fs_sel;
        pu_dm_en = pull && !up_fs_sel;
        link_off = !pull;
        spd_err  = (st_q == LINK_FAULT);
    end

endmodule

// File: rtl/iso_attach_sup.sv
module iso_attach_sup #(
    parameter int LOSS_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_pwr_ok,
    input  logic dn_pwr_ok,
    input  logic pu_req,
    input  logic pd_strap,
    input  logic up_fs_sel,
    input  logic dn_fs_sel,
    input  logic bit_tick,
    output logic pu_dp_en,
    output logic pu_dm_en,
    output logic pd_en,
    output logic up_drv_off,
    output logic dn_drv_off,
    output logic spd_err
);

    localparam int SIDES = 2;   // index 0 watches host power, 1 watches peripheral power

    logic [SIDES-1:0] watch;
    logic [SIDES-1:0] expire_w;
    logic [SIDES-1:0] forced;
    logic             link_off;

    assign watch = {dn_pwr_ok, up_pwr_ok};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        logic forced_q;

        iso_loss_timer #(.LOSS_TICKS(LOSS_TICKS)) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .pwr_ok   (watch[s]),
            .bit_tick (bit_tick),
            .expire   (expire_w[s])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           forced_q <= 1'b1;
            else if (watch[s])    forced_q <= 1'b0;
            else if (expire_w[s]) forced_q <= 1'b1;
        end

        assign forced[s] = forced_q;
    end

    iso_strap_latch u_strap (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (pd_strap),
        .pd_en (pd_en)
    );

    iso_attach_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .up_pwr_ok   (up_pwr_ok),
        .dn_pwr_ok   (dn_pwr_ok),
        .pu_req      (pu_req),
        .up_fs_sel   (up_fs_sel),
        .dn_fs_sel   (dn_fs_sel),
        .hold_expire (expire_w[1]),
        .pu_dp_en    (pu_dp_en),
        .pu_dm_en    (pu_dm_en),
        .link_off    (link_off),
        .spd_err     (spd_err)
    );

    assign up_drv_off = link_off | forced[1];
    assign dn_drv_off = forced[0];

endmodule

// File: rtl/iso_attach_sup_chk.sv
module iso_attach_sup_chk #(
    parameter int LOSS_TICKS = 32
) (
    input logic clk,
    input logic rst_n,
    input logic up_pwr_ok,
    input logic dn_pwr_ok,
    input logic pu_req,
    input logic pd_strap,
    input logic up_fs_sel,
    input logic dn_fs_sel,
    input logic bit_tick,
    input logic pu_dp_en,
    input logic pu_dm_en,
    input logic pd_en,
    input logic up_drv_off,
    input logic dn_drv_off,
    input logic spd_err
);

    localparam int CW = $clog2(LOSS_TICKS + 2) + 1;
    localparam logic [CW-1:0] TOP = CW'(LOSS_TICKS + 1);

    logic [CW-1:0] up_loss_cnt;
    logic [CW-1:0] dn_loss_cnt;
    logic [1:0]    edges;
    logic          pu_any;
    logic          strap_seen;

    assign pu_any     = pu_dp_en | pu_dm_en;
    assign strap_seen = pd_strap | !pd_strap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_loss_cnt <= '0;
            dn_loss_cnt <= '0;
            edges       <= '0;
        end else begin
            if (edges != 2'd2) edges <= edges + 2'd1;
            if (up_pwr_ok)                          up_loss_cnt <= '0;
            else if (bit_tick && up_loss_cnt != TOP) up_loss_cnt <= up_loss_cnt + 1'b1;
            if (dn_pwr_ok)                          dn_loss_cnt <= '0;
            else if (bit_tick && dn_loss_cnt != TOP) dn_loss_cnt <= dn_loss_cnt + 1'b1;
        end
    end

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (edges == 2'd2 && strap_seen) |-> $stable(pd_en)); // R2
    AST_PU_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(pu_any) |-> ($past(pu_req) && $past(up_pwr_ok) && $past(dn_pwr_ok))); // R3
    AST_REQ_DROP_DETACH: assert property (@(posedge clk) disable iff (!rst_n) (!pu_req && dn_pwr_ok) |=> !pu_any); // R3
    AST_DP_FULL_SPEED: assert property (@(posedge clk) disable iff (!rst_n) pu_dp_en |-> up_fs_sel); // R4
    AST_DM_LOW_SPEED: assert property (@(posedge clk) disable iff (!rst_n) pu_dm_en |-> !up_fs_sel); // R4
    AST_HOST_LOSS_DETACH: assert property (@(posedge clk) disable iff (!rst_n) !up_pwr_ok |=> (!pu_any && up_drv_off)); // R5
    AST_UP_RELEASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (dn_loss_cnt > CW'(LOSS_TICKS)) |-> (!pu_any && up_drv_off)); // R6
    AST_DN_RELEASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (up_loss_cnt > CW'(LOSS_TICKS)) |-> dn_drv_off); // R8
    AST_DN_ENABLE_ON_POWER: assert property (@(posedge clk) disable iff (!rst_n) up_pwr_ok |=> !dn_drv_off); // R9
    AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (up_fs_sel != dn_fs_sel) |=> spd_err); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) spd_err |=> spd_err); // R10
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) spd_err |-> (!pu_any && up_drv_off)); // R10

endmodule

bind iso_attach_sup iso_attach_sup_chk #(.LOSS_TICKS(LOSS_TICKS)) u_chk (.*);

// File: tb/tb_iso_attach_sup.sv
module tb_iso_attach_sup;

    localparam int CLK_PERIOD = 10;
    localparam int LOSS_TICKS = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_pwr_ok = 1'b0, dn_pwr_ok = 1'b0, pu_req = 1'b0, pd_strap = 1'b1;
    logic up_fs_sel = 1'b1, dn_fs_sel = 1'b1, bit_tick = 1'b1;
    logic pu_dp_en, pu_dm_en, pd_en, up_drv_off, dn_drv_off, spd_err;

    int    checks = 0;
    int    fails  = 0;
    bit    tick_rand = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    iso_attach_sup #(.LOSS_TICKS(LOSS_TICKS)) dut (
        .clk, .rst_n, .up_pwr_ok, .dn_pwr_ok, .pu_req, .pd_strap,
        .up_fs_sel, .dn_fs_sel, .bit_tick,
        .pu_dp_en, .pu_dm_en, .pd_en, .up_drv_off, .dn_drv_off, .spd_err
    );

    // behavioural reference model
    bit m_att, m_hold, m_fault, m_strap, m_taken;
    bit m_arm[2], m_drain[2], m_forced[2];
    int m_cnt[2];

    always @(posedge clk) begin
        bit pw[2];
        bit ex[2];
        if (!rst_n) begin
            m_att = 0; m_hold = 0; m_fault = 0; m_strap = 0; m_taken = 0;
            for (int s = 0; s < 2; s++) begin
                m_arm[s] = 0; m_drain[s] = 0; m_forced[s] = 1; m_cnt[s] = 0;
            end
        end else begin
            pw[0] = up_pwr_ok;
            pw[1] = dn_pwr_ok;
            for (int s = 0; s < 2; s++)
                ex[s] = !pw[s] && m_drain[s] && bit_tick && (m_cnt[s] == LOSS_TICKS - 1);
            if (!m_fault) begin
                if (up_fs_sel != dn_fs_sel) begin
                    m_fault = 1; m_att = 0; m_hold = 0;
                end else if (m_hold) begin
                    if (!up_pwr_ok) m_hold = 0;
                    else if (dn_pwr_ok) begin m_hold = 0; m_att = pu_req; end
                    else if (ex[1]) m_hold = 0;
                end else if (m_att) begin
                    if (!up_pwr_ok) m_att = 0;
                    else if (!dn_pwr_ok) begin m_att = 0; m_hold = 1; end
                    else if (!pu_req) m_att = 0;
                end else if (pu_req && up_pwr_ok && dn_pwr_ok) begin
                    m_att = 1;
                end
            end
            for (int s = 0; s < 2; s++) begin
                if (pw[s]) begin
                    m_arm[s] = 1; m_drain[s] = 0; m_cnt[s] = 0; m_forced[s] = 0;
                end else if (m_arm[s]) begin
                    m_arm[s] = 0; m_drain[s] = 1; m_cnt[s] = 0;
                end else if (m_drain[s] && bit_tick) begin
                    if (ex[s]) begin m_drain[s] = 0; m_forced[s] = 1; end
                    else m_cnt[s]++;
                end
            end
            if (!m_taken) begin m_taken = 1; m_strap = pd_strap; end
        end
    end

    function automatic logic [5:0] outs();
        return {pu_dp_en, pu_dm_en, pd_en, up_drv_off, dn_drv_off, spd_err};
    endfunction

    task automatic check(input logic [5:0] got, input logic [5:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b (dp dm pd upoff dnoff err) t=%0t",
                     cur_req, what, got, exp, $time);
        end
    endtask

    task automatic compare_model();
        bit pull;
        pull = m_att | m_hold;
        check(outs(), {pull & up_fs_sel, pull & !up_fs_sel, m_strap,
                       !pull | m_forced[1], m_forced[0], m_fault}, "model");
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_model();
            bit_tick = tick_rand ? 1'($urandom_range(0, 1)) : 1'b1;
        end
    endtask

    task automatic expect_now(input logic [5:0] exp, input string req);
        cur_req = req;
        check(outs(), exp, "directed");
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog all: actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1 reset state, R2 strap capture
        cur_req = "R1";
        cyc(2);
        expect_now(6'b000110, "R1");
        rst_n = 1'b1;
        cyc(1);
        expect_now(6'b001110, "R2");
        pd_strap = 1'b0;
        cyc(3);
        expect_now(6'b001110, "R2");

        // R9 downstream drivers released once host power is seen
        up_pwr_ok = 1'b1; dn_pwr_ok = 1'b1;
        cyc(1);
        expect_now(6'b001100, "R9");

        // R3 attach / withdraw, R4 full speed on D+
        pu_req = 1'b1;
        cyc(1);
        expect_now(6'b101000, "R3");
        expect_now(6'b101000, "R4");
        pu_req = 1'b0;
        cyc(1);
        expect_now(6'b001100, "R3");
        pu_req = 1'b1;
        cyc(1);

        // R6 peripheral power loss holds for LOSS_TICKS-1 ticks, request ignored
        dn_pwr_ok = 1'b0; pu_req = 1'b0;
        cyc(1);
        expect_now(6'b101000, "R6");
        cyc(LOSS_TICKS - 1);
        expect_now(6'b101000, "R6");
        cyc(1);
        expect_now(6'b001100, "R6");

        // R7 brief return restarts the count
        dn_pwr_ok = 1'b1; pu_req = 1'b1;
        cyc(2);
        dn_pwr_ok = 1'b0;
        cyc(20);
        dn_pwr_ok = 1'b1;
        cyc(1);
        expect_now(6'b101000, "R7");
        dn_pwr_ok = 1'b0;
        cyc(LOSS_TICKS);
        expect_now(6'b101000, "R7");
        cyc(1);
        expect_now(6'b001100, "R7");
        dn_pwr_ok = 1'b1;
        cyc(1);

        // R5 host loss detaches at once, R8 bounded downstream release
        up_pwr_ok = 1'b0;
        cyc(1);
        expect_now(6'b001100, "R5");
        cyc(LOSS_TICKS - 1);
        expect_now(6'b001100, "R8");
        cyc(1);
        expect_now(6'b001110, "R8");
        up_pwr_ok = 1'b1;
        cyc(1);
        expect_now(6'b101000, "R8");

        // R4 low speed uses D-
        up_fs_sel = 1'b0; dn_fs_sel = 1'b0;
        cyc(1);
        expect_now(6'b011000, "R4");

        // random traffic against the model (R3 R5 R6 R7 R8)
        cur_req = "R6 random";
        tick_rand = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 59) == 0) up_pwr_ok = ~up_pwr_ok;
            if ($urandom_range(0, 49) == 0) dn_pwr_ok = ~dn_pwr_ok;
            if ($urandom_range(0, 9) == 0)  pu_req = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 299) == 0) begin
                up_fs_sel = ~up_fs_sel; dn_fs_sel = up_fs_sel;
            end
            pd_strap = 1'($urandom_range(0, 1));
            cyc(1);
        end
        tick_rand = 1'b0;

        // R10 mismatch is sticky until reset
        rst_n = 1'b0; pd_strap = 1'b0;
        cur_req = "R1";
        cyc(2);
        expect_now(6'b000110, "R1");
        up_pwr_ok = 1'b1; dn_pwr_ok = 1'b1; pu_req = 1'b1;
        up_fs_sel = 1'b1; dn_fs_sel = 1'b1;
        rst_n = 1'b1;
        cyc(1);
        expect_now(6'b100000, "R2");
        dn_fs_sel = 1'b0;
        cyc(1);
        expect_now(6'b000101, "R10");
        dn_fs_sel = 1'b1;
        cyc(3);
        expect_now(6'b000101, "R10");
        rst_n = 1'b0;
        cyc(1);
        expect_now(6'b000110, "R1");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule